// File: doc/BRIEF.md
# Event Counter Unit

This block counts hardware events for performance analysis. It sits beside a unit that raises single-cycle event pulses on a wide input vector, and it gives software eight 48-bit counters behind a plain register bus. Each counter is bound to one event line through an 8-bit code. A counter advances only while the unit-wide run bit and its own enable bit are both set.

When a running counter rolls over from its all-ones value to zero, a pending flag for that counter is set. The interrupt line is the registered OR of the pending flags that are not masked. Software clears flags by writing ones to a clear register. After reset every interrupt is masked and every counter is bound to the "no event" code 0xFF.

Register writes take effect on the clock edge that samples them. Reads are registered, so data for an address appears one cycle after that address is presented.

Top module: `evt_count_unit`

## Requirements
- R1: After reset, all counters, the run bit and the counter enables read zero. The pending flags read zero. The mask register reads 0xFF. Both select registers read 0xFFFFFFFF. The interrupt output is low.
- R2: Counter n is read and written as 64 bits at offset 0x1E00 + 8*n. Bits 63:48 always read zero and writes to them are ignored.
- R3: Counters 0-3 take their codes from the select register at 0x1D00, and counters 4-7 from the one at 0x1D04. Counter n uses bits 8*(n mod 4)+7 : 8*(n mod 4). While counting is allowed, the counter gains one on every cycle in which event input bit [code] is high.
- R4: Code 0xFF never counts. Any code at or above the number of event inputs (128) also never counts; it does not alias onto a lower input.
- R5: Bit 17 of the control register at 0x0408 is the run bit. While it is clear, no counter changes on events.
- R6: Bit n of the register at 0x1C00 enables counter n. A counter with its bit clear does not count, even while the run bit is set.
- R7: When a counting increment takes counter n from 2^48-1 to 0, pending bit n at 0x0808 is set on that same edge.
- R8: Writing to 0x080C clears pending bit n for each written bit n that is 1. Bits written as 0 leave their flags unchanged.
- R9: Mask bit n at 0x0800 equal to 1 blocks counter n's interrupt. The interrupt output goes high one cycle after a pending bit and a clear mask bit coincide, and goes low one cycle after that condition ends.
- R10: The read-only register at 0x1CF0 returns the VERSION parameter (default 0x00010300).
- R11: Read data appears one cycle after the address. Unmapped or misaligned addresses read zero.
- R12: A bus write to a counter in the same cycle as a counting event stores the written value. The event is lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 16 | Register byte address |
| reg_wr | input | 1 | Write strobe for the current address |
| reg_wdata | input | 64 | Write data (32-bit registers use bits 31:0) |
| reg_rdata | output | 64 | Registered read data |
| evt_in | input | 128 | Event pulse inputs, indexed by event code |
| irq_out | output | 1 | Registered overflow interrupt |

## Verification
A wrong counter, select byte or enable bit can only be seen in the value read back from a counter slot. That value appears one cycle after its address is presented. A wrong select lane shows up as a count on the wrong counter, and a truncated code shows up as a count from an aliased input line. A wrong pending or mask bit is seen in two places: in the status readback on the edge of the wrap or clear, and on the interrupt pin exactly one cycle later. The bench therefore samples the interrupt only after that extra cycle.

// File: rtl/evt_count_pkg.sv
package evt_count_pkg;
  localparam int ADDR_W        = 16;
  localparam int DATA_W        = 64;
  localparam int CODE_W        = 8;
  localparam int CODES_PER_SEL = 4;
  localparam int RUN_BIT       = 17;

  localparam logic [ADDR_W-1:0] A_CTRL = 16'h0408;
  localparam logic [ADDR_W-1:0] A_MASK = 16'h0800;
  localparam logic [ADDR_W-1:0] A_PEND = 16'h0808;
  localparam logic [ADDR_W-1:0] A_CLR  = 16'h080C;
  localparam logic [ADDR_W-1:0] A_ENA  = 16'h1C00;
  localparam logic [ADDR_W-1:0] A_VER  = 16'h1CF0;
  localparam logic [ADDR_W-1:0] A_SEL  = 16'h1D00;
  localparam logic [ADDR_W-1:0] A_CNT  = 16'h1E00;
endpackage

// File: rtl/evt_cnt_slice.sv
module evt_cnt_slice #(
  parameter int CNT_W   = 48,
  parameter int CODE_W  = 8,
  parameter int NUM_EVT = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_i,
  input  logic              ena_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic              wr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              wrap_o
);
  localparam int EVT_IW = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;
  localparam logic [CODE_W:0] EVT_LIM = (CODE_W+1)'(NUM_EVT);

  logic [CNT_W-1:0] cnt_q;
  logic             code_ok;
  logic             hit;
  logic             inc;

  assign code_ok = (code_i != {CODE_W{1'b1}}) && ({1'b0, code_i} < EVT_LIM);
  assign hit     = code_ok && evt_i[code_i[EVT_IW-1:0]];
  assign inc     = run_i && ena_i && hit;
  assign wrap_o  = inc && !wr_i && (&cnt_q);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (wr_i) cnt_q <= wdata_i;
    else if (inc)  cnt_q <= cnt_q + 1'b1;
  end

  AST_RUN_GATE: assert property (@(posedge clk) disable iff (rst)
    (!run_i && !wr_i) |=> $stable(cnt_q)); // R5
  AST_ENA_GATE: assert property (@(posedge clk) disable iff (rst)
    (!ena_i && !wr_i) |=> $stable(cnt_q)); // R6
  AST_NONE_CODE: assert property (@(posedge clk) disable iff (rst)
    ((code_i == {CODE_W{1'b1}}) && !wr_i) |=> $stable(cnt_q)); // R4
  AST_ROLL_ZERO: assert property (@(posedge clk) disable iff (rst)
    wrap_o |=> (cnt_q == '0)); // R7
  AST_WR_WINS: assert property (@(posedge clk) disable iff (rst)
    wr_i |=> (cnt_q == $past(wdata_i))); // R12
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl #(
  parameter int NUM_CNT = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_CNT-1:0] wrap_i,
  input  logic               mask_wr_i,
  input  logic               clr_wr_i,
  input  logic [NUM_CNT-1:0] wdata_i,
  output logic [NUM_CNT-1:0] mask_o,
  output logic [NUM_CNT-1:0] pend_o,
  output logic               irq_o
);
  logic [NUM_CNT-1:0] mask_q;
  logic [NUM_CNT-1:0] pend_q;
  logic [NUM_CNT-1:0] clr_vec;
  logic               irq_q;

  assign clr_vec = clr_wr_i ? wdata_i : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
      pend_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (mask_wr_i) mask_q <= wdata_i;
      pend_q <= (pend_q & ~clr_vec) | wrap_i;
      irq_q  <= |(pend_q & ~mask_q);
    end
  end

  assign mask_o = mask_q;
  assign pend_o = pend_q;
  assign irq_o  = irq_q;

  AST_PEND_SET: assert property (@(posedge clk) disable iff (rst)
    (wrap_i != '0) |=> ((pend_q & $past(wrap_i)) == $past(wrap_i))); // R7
  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (rst)
    (clr_wr_i && (wrap_i == '0)) |=> ((pend_q & $past(wdata_i)) == '0)); // R8
  AST_ALL_MASKED: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '1) |=> !irq_q); // R9
endmodule

// File: rtl/evt_count_unit.sv
module evt_count_unit
  import evt_count_pkg::*;
#(
  parameter int          NUM_CNT = 8,
  parameter int          CNT_W   = 48,
  parameter int          NUM_EVT = 128,
  parameter logic [31:0] VERSION = 32'h0001_0300
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [15:0]        reg_addr,
  input  logic               reg_wr,
  input  logic [63:0]        reg_wdata,
  output logic [63:0]        reg_rdata,
  input  logic [NUM_EVT-1:0] evt_in,
  output logic               irq_out
);
  localparam int NUM_SEL = (NUM_CNT + CODES_PER_SEL - 1) / CODES_PER_SEL;
  localparam int CIW     = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1;
  localparam int SIW     = (NUM_SEL > 1) ? $clog2(NUM_SEL) : 1;
  localparam logic [ADDR_W-1:0] CNT_SPAN = ADDR_W'(8 * NUM_CNT);
  localparam logic [ADDR_W-1:0] SEL_SPAN = ADDR_W'(4 * NUM_SEL);

  logic               run_q;
  logic [NUM_CNT-1:0] ena_q;
  logic [31:0]        sel_q [NUM_SEL];
  logic [CNT_W-1:0]   cnt_val [NUM_CNT];
  logic [NUM_CNT-1:0] wrap_vec;
  logic [NUM_CNT-1:0] mask_w;
  logic [NUM_CNT-1:0] pend_w;
  logic [DATA_W-1:0]  rd_nxt;
  logic [DATA_W-1:0]  rdata_q;
  logic [ADDR_W-1:0]  cnt_off;
  logic [ADDR_W-1:0]  sel_off;
  logic               cnt_rd_hit;
  logic               sel_rd_hit;

  // control and enable registers
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      ena_q <= '0;
    end else if (reg_wr) begin
      if (reg_addr == A_CTRL) run_q <= reg_wdata[RUN_BIT];
      if (reg_addr == A_ENA)  ena_q <= reg_wdata[NUM_CNT-1:0];
    end
  end

  // event select registers, four codes each
  for (genvar k = 0; k < NUM_SEL; k++) begin : g_sel
    localparam logic [ADDR_W-1:0] SEL_ADDR = A_SEL + ADDR_W'(4 * k);
    always_ff @(posedge clk) begin
      if (rst)                                  sel_q[k] <= '1;
      else if (reg_wr && reg_addr == SEL_ADDR)  sel_q[k] <= reg_wdata[31:0];
    end
  end

  // counters
  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    localparam logic [ADDR_W-1:0] CNT_ADDR = A_CNT + ADDR_W'(8 * i);
    localparam int SREG = i / CODES_PER_SEL;
    localparam int LANE = i % CODES_PER_SEL;
    logic cnt_wr;
    assign cnt_wr = reg_wr && (reg_addr == CNT_ADDR);
    evt_cnt_slice #(
      .CNT_W  (CNT_W),
      .CODE_W (CODE_W),
      .NUM_EVT(NUM_EVT)
    ) u_slice (
      .clk    (clk),
      .rst    (rst),
      .run_i  (run_q),
      .ena_i  (ena_q[i]),
      .code_i (sel_q[SREG][CODE_W*LANE +: CODE_W]),
      .evt_i  (evt_in),
      .wr_i   (cnt_wr),
      .wdata_i(reg_wdata[CNT_W-1:0]),
      .cnt_o  (cnt_val[i]),
      .wrap_o (wrap_vec[i])
    );
  end

  evt_irq_ctrl #(.NUM_CNT(NUM_CNT)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .wrap_i   (wrap_vec),
    .mask_wr_i(reg_wr && (reg_addr == A_MASK)),
    .clr_wr_i (reg_wr && (reg_addr == A_CLR)),
    .wdata_i  (reg_wdata[NUM_CNT-1:0]),
    .mask_o   (mask_w),
    .pend_o   (pend_w),
    .irq_o    (irq_out)
  );

  // read path
  assign cnt_off    = reg_addr - A_CNT;
  assign sel_off    = reg_addr - A_SEL;
  assign cnt_rd_hit = (reg_addr >= A_CNT) && (cnt_off < CNT_SPAN) && (cnt_off[2:0] == 3'd0);
  assign sel_rd_hit = (reg_addr >= A_SEL) && (sel_off < SEL_SPAN) && (sel_off[1:0] == 2'd0);

  always_comb begin
    rd_nxt = '0;
    if (cnt_rd_hit)               rd_nxt = DATA_W'(cnt_val[cnt_off[3 +: CIW]]);
    else if (sel_rd_hit)          rd_nxt = DATA_W'(sel_q[sel_off[2 +: SIW]]);
    else if (reg_addr == A_CTRL)  rd_nxt = DATA_W'(run_q) << RUN_BIT;
    else if (reg_addr == A_ENA)   rd_nxt = DATA_W'(ena_q);
    else if (reg_addr == A_MASK)  rd_nxt = DATA_W'(mask_w);
    else if (reg_addr == A_PEND)  rd_nxt = DATA_W'(pend_w);
    else if (reg_addr == A_VER)   rd_nxt = DATA_W'(VERSION);
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_nxt;
  end

  assign reg_rdata = rdata_q;

  AST_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[DATA_W-1:CNT_W] == '0); // R2
  AST_RUN_IDLE_IRQ: assert property (@(posedge clk) disable iff (rst)
    (pend_w == '0) |=> !irq_out); // R9
endmodule

// File: tb/evt_count_unit_test.sv
`timescale 1ns/1ps
module evt_count_unit_test;
  localparam int  NEV  = 128;
  localparam time TCLK = 20;

  // counter, code, pulsed input, pulses, expected count
  localparam int VEC [8][5] = '{
    '{0,   5,   5, 3, 3},
    '{1,   5,   6, 4, 0},
    '{2, 255,   9, 4, 0},
    '{3,   9,   9, 6, 6},
    '{4, 127, 127, 2, 2},
    '{5, 200,  72, 3, 0},
    '{6,   0,   0, 5, 5},
    '{7,  64,  64, 1, 1}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic [NEV-1:0] evt_in = '0;
  logic        irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0]  sh_sel [8];
  logic [63:0] rv;

  evt_count_unit uut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in), .irq_out(irq_out)
  );

  always #(TCLK/2) clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [63:0] d);
    @(negedge clk);
    reg_addr = a; reg_wr = 1'b0;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic pulse(input int b, input int n);
    for (int p = 0; p < n; p++) begin
      @(negedge clk);
      evt_in = '0; evt_in[b] = 1'b1;
      @(negedge clk);
      evt_in = '0;
    end
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic set_code(input int c, input logic [7:0] code);
    sh_sel[c] = code;
    wr(16'h1D00 + 16'(4 * (c / 4)),
       {32'h0, sh_sel[4*(c/4)+3], sh_sel[4*(c/4)+2], sh_sel[4*(c/4)+1], sh_sel[4*(c/4)]});
  endtask

  initial begin
    #(TCLK * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) sh_sel[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq", {63'h0, irq_out}, 64'h0);
    rd(16'h0800, rv); chk("R1 mask", rv, 64'hFF);
    rd(16'h0808, rv); chk("R1 pend", rv, 64'h0);
    rd(16'h1C00, rv); chk("R1 ena", rv, 64'h0);
    rd(16'h0408, rv); chk("R1 ctrl", rv, 64'h0);
    rd(16'h1D00, rv); chk("R1 sel0", rv, 64'hFFFF_FFFF);
    rd(16'h1D04, rv); chk("R1 sel1", rv, 64'hFFFF_FFFF);
    rd(16'h1E18, rv); chk("R1 cnt3", rv, 64'h0);

    // R3/R4 table walk: select lanes, matching and non-matching events
    for (int i = 0; i < 8; i++) begin
      int c;
      c = VEC[i][0];
      wr(16'h1E00 + 16'(8 * c), 64'h0);
      set_code(c, 8'(VEC[i][1]));
      wr(16'h1C00, 64'(1) << c);
      wr(16'h0408, 64'h2_0000);
      pulse(VEC[i][2], VEC[i][3]);
      wr(16'h0408, 64'h0);
      rd(16'h1E00 + 16'(8 * c), rv);
      chk($sformatf("R3/R4 vec%0d", i), rv, 64'(VEC[i][4]));
    end

    // R2 upper bits ignored
    wr(16'h1E00, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(16'h1E00, rv); chk("R2 upper zero", rv, 64'h0000_FFFF_FFFF_FFFF);

    // R5 run bit clear blocks counting
    set_code(0, 8'd5);
    wr(16'h1C00, 64'h1);
    pulse(5, 3);
    rd(16'h1E00, rv); chk("R5 run off", rv, 64'h0000_FFFF_FFFF_FFFF);

    // R6 counter enable clear blocks counting
    wr(16'h1C00, 64'h0);
    wr(16'h0408, 64'h2_0000);
    pulse(5, 2);
    rd(16'h1E00, rv); chk("R6 ena off", rv, 64'h0000_FFFF_FFFF_FFFF);

    // R7 wrap sets pending
    wr(16'h1C00, 64'h1);
    pulse(5, 1);
    rd(16'h1E00, rv); chk("R7 wrap value", rv, 64'h0);
    rd(16'h0808, rv); chk("R7 pend set", rv, 64'h1);

    // R9 masked then unmasked
    idle();
    chk("R9 masked irq", {63'h0, irq_out}, 64'h0);
    wr(16'h0800, 64'hFE);
    idle();
    chk("R9 unmasked irq", {63'h0, irq_out}, 64'h1);

    // R8 clear with zeros has no effect, with one clears
    wr(16'h080C, 64'hFE);
    rd(16'h0808, rv); chk("R8 zero no clear", rv, 64'h1);
    wr(16'h080C, 64'h01);
    rd(16'h0808, rv); chk("R8 clear", rv, 64'h0);
    chk("R9 irq drop", {63'h0, irq_out}, 64'h0);

    // R12 write beats simultaneous event
    set_code(2, 8'd3);
    wr(16'h1C00, 64'h4);
    @(negedge clk);
    reg_addr = 16'h1E10; reg_wdata = 64'd100; reg_wr = 1'b1; evt_in = '0; evt_in[3] = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; evt_in = '0;
    rd(16'h1E10, rv); chk("R12 write wins", rv, 64'd100);
    pulse(3, 1);
    rd(16'h1E10, rv); chk("R3 count after write", rv, 64'd101);

    // R10 version, R11 unmapped and misaligned
    rd(16'h1CF0, rv); chk("R10 version", rv, 64'h0001_0300);
    rd(16'h0100, rv); chk("R11 unmapped", rv, 64'h0);
    rd(16'h1E04, rv); chk("R11 misaligned", rv, 64'h0);
    @(negedge clk);
    reg_addr = 16'h1CF0;
    @(posedge clk); #1;
    reg_addr = 16'h0100;
    @(negedge clk);
    chk("R11 latency", reg_rdata, 64'h0001_0300);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule